// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block decides which DMA transfer mode a storage drive should run at. It weighs the drive's identify capability words against the host controller's own capability masks. Three families are searched in priority order: ultra, then multiword, then single-word. Within the first family that has any usable mode, the block takes the fastest mode. That choice is then capped by a mode ceiling requested by software.

The block also applies two qualifications. When no 80-wire cable is detected, the upper ultra modes are withheld. When the newer timing words of the identify data are not valid, the single-word capability is rebuilt from an older timing value. A packet (non-disk) device gets no DMA at all when the host forbids DMA for such devices.

A request is a one-cycle `start` pulse with all inputs valid in that cycle. The registered result appears in the following cycle, together with a one-cycle `done`.

Top module: `dma_mode_sel`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done` is 0 and `mode` is 0x00.
- R2: A `start` in cycle n gives `done`=1 in cycle n+1, with `mode` updated in that same cycle. `done` is 0 in every other cycle, and `mode` holds its value when `start` is low.
- R3: Mode codes are 0x40+n for ultra mode n, 0x20+n for multiword mode n and 0x10+n for single-word mode n. The families are tried in the order ultra, multiword, single-word. A family is skipped when `req_mode` is below its base code.
- R4: The ultra family is usable only when `id_ok` bit 2 is 1. Its mask is `host_udma` AND `drv_udma`.
- R5: When `req_mode` > 0x42, the ultra mask has any bit of 3..6 set and `cable80` is 0, the ultra mask is cut to bits 0..2.
- R6: The multiword and single-word masks come from the drive words only when `id_ok` bit 1 is 1. Each is ANDed with its host mask.
- R7: When `id_ok` bit 1 is 0 and `drv_sw_legacy` is 1 or 2, the single-word mask is ((2<<value)-1) AND `host_swdma`. Any other legacy value gives an empty mask.
- R8: The chosen mode is the family base plus the index of the highest set bit in the first nonempty family mask. It is then lowered to `req_mode` when it exceeds it.
- R9: When `is_disk` is 0 and `host_no_pkt_dma` is 1, the result is 0x00.
- R10: When every usable family mask is empty, the result is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request; all other inputs sampled here |
| id_ok | input | 3 | Identify field-valid bits (bit 1 timing words, bit 2 ultra word) |
| drv_udma | input | UDMA_N | Drive ultra mode mask |
| drv_mwdma | input | MDMA_N | Drive multiword mode mask |
| drv_swdma | input | SDMA_N | Drive single-word mode mask |
| drv_sw_legacy | input | 8 | Legacy single-word timing mode value |
| host_udma | input | UDMA_N | Host ultra mode mask |
| host_mwdma | input | MDMA_N | Host multiword mode mask |
| host_swdma | input | SDMA_N | Host single-word mode mask |
| cable80 | input | 1 | 80-wire cable detected |
| is_disk | input | 1 | Device is a disk (not a packet device) |
| host_no_pkt_dma | input | 1 | Host forbids DMA on packet devices |
| req_mode | input | 8 | Requested mode ceiling code |
| done | output | 1 | Result valid pulse |
| mode | output | 8 | Chosen mode code, 0x00 for none |

## Verification
The assertions assume that every input is valid in the cycle `start` is high, because checks on the result look back one cycle at `req_mode`, `cable80`, `id_ok` and the device flags. They also assume that `start` is a single-cycle pulse. The stimulus sets all inputs and raises `start` in the same cycle, then drops `start` in the next. Between requests it changes inputs only while `start` is low, which the hold check relies on to show that the result ignores them.

// File: rtl/dma_mode_sel_pkg.sv
package dma_mode_sel_pkg;
  localparam logic [7:0] UDMA_BASE = 8'h40;
  localparam logic [7:0] MDMA_BASE = 8'h20;
  localparam logic [7:0] SDMA_BASE = 8'h10;
  localparam logic [7:0] UDMA_SLOW_TOP = 8'h42;

  typedef enum logic [1:0] {FAM_ULTRA = 2'd0, FAM_MWORD = 2'd1, FAM_SWORD = 2'd2} fam_e;

  // index of the highest set bit (0 when empty)
  function automatic logic [2:0] top_bit(input logic [7:0] m);
    logic [2:0] r;
    r = '0;
    for (int i = 0; i < 8; i++)
      if (m[i]) r = i[2:0];
    return r;
  endfunction

  // mask of single-word modes 0..t when the legacy value is 1 or 2
  function automatic logic [7:0] legacy_sw_mask(input logic [7:0] t);
    if (t != 8'd0 && t <= 8'd2)
      return (8'd2 << t[1:0]) - 8'd1;
    return 8'd0;
  endfunction
endpackage

// File: rtl/dma_fam_mask.sv
module dma_fam_mask
  import dma_mode_sel_pkg::*;
#(
  parameter fam_e FAMILY = FAM_ULTRA,
  parameter int   W      = 7
) (
  input  logic [2:0]   id_ok,
  input  logic [W-1:0] drv,
  input  logic [W-1:0] host,
  input  logic [7:0]   legacy,
  input  logic         cable80,
  input  logic [7:0]   req_mode,
  output logic [W-1:0] mask
);
  logic [W-1:0] raw;
  assign raw = drv & host;

  generate
    if (FAMILY == FAM_ULTRA) begin : g_ultra
      localparam logic [W-1:0] SLOW = W'(7);
      logic fast_bits;
      assign fast_bits = |(raw & ~SLOW);
      always_comb begin
        mask = id_ok[2] ? raw : '0;
        if (req_mode > UDMA_SLOW_TOP && fast_bits && !cable80)
          mask = mask & SLOW;
      end
    end else if (FAMILY == FAM_MWORD) begin : g_mword
      assign mask = id_ok[1] ? raw : '0;
    end else begin : g_sword
      logic [7:0] leg;
      assign leg = legacy_sw_mask(legacy);
      assign mask = id_ok[1] ? raw : (leg[W-1:0] & host);
    end
  endgenerate
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
  import dma_mode_sel_pkg::*;
#(
  parameter int UW = 7,
  parameter int MW = 3,
  parameter int SW = 3
) (
  input  logic [UW-1:0] u_mask,
  input  logic [MW-1:0] m_mask,
  input  logic [SW-1:0] s_mask,
  input  logic [7:0]    req_mode,
  output logic [7:0]    pick_mode
);
  logic [7:0] u8, m8, s8;
  logic [7:0] raw_mode;

  always_comb begin
    u8 = '0; m8 = '0; s8 = '0;
    u8[UW-1:0] = u_mask;
    m8[MW-1:0] = m_mask;
    s8[SW-1:0] = s_mask;
  end

  always_comb begin
    if (req_mode >= UDMA_BASE && |u8)
      raw_mode = UDMA_BASE + {5'd0, top_bit(u8)};
    else if (req_mode >= MDMA_BASE && |m8)
      raw_mode = MDMA_BASE + {5'd0, top_bit(m8)};
    else if (req_mode >= SDMA_BASE && |s8)
      raw_mode = SDMA_BASE + {5'd0, top_bit(s8)};
    else
      raw_mode = 8'h00;
    pick_mode = (raw_mode > req_mode) ? req_mode : raw_mode;
  end
endmodule

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
  import dma_mode_sel_pkg::*;
#(
  parameter int UDMA_N = 7,
  parameter int MDMA_N = 3,
  parameter int SDMA_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        id_ok,
  input  logic [UDMA_N-1:0] drv_udma,
  input  logic [MDMA_N-1:0] drv_mwdma,
  input  logic [SDMA_N-1:0] drv_swdma,
  input  logic [7:0]        drv_sw_legacy,
  input  logic [UDMA_N-1:0] host_udma,
  input  logic [MDMA_N-1:0] host_mwdma,
  input  logic [SDMA_N-1:0] host_swdma,
  input  logic              cable80,
  input  logic              is_disk,
  input  logic              host_no_pkt_dma,
  input  logic [7:0]        req_mode,
  output logic              done,
  output logic [7:0]        mode
);
  logic [UDMA_N-1:0] u_mask;
  logic [MDMA_N-1:0] m_mask;
  logic [SDMA_N-1:0] s_mask;
  logic [7:0]        pick_mode;
  logic              pkt_block;
  logic [7:0]        next_mode;

  dma_fam_mask #(.FAMILY(FAM_ULTRA), .W(UDMA_N)) u_fam_u (
    .id_ok(id_ok), .drv(drv_udma), .host(host_udma), .legacy(drv_sw_legacy),
    .cable80(cable80), .req_mode(req_mode), .mask(u_mask));

  dma_fam_mask #(.FAMILY(FAM_MWORD), .W(MDMA_N)) u_fam_m (
    .id_ok(id_ok), .drv(drv_mwdma), .host(host_mwdma), .legacy(drv_sw_legacy),
    .cable80(cable80), .req_mode(req_mode), .mask(m_mask));

  dma_fam_mask #(.FAMILY(FAM_SWORD), .W(SDMA_N)) u_fam_s (
    .id_ok(id_ok), .drv(drv_swdma), .host(host_swdma), .legacy(drv_sw_legacy),
    .cable80(cable80), .req_mode(req_mode), .mask(s_mask));

  dma_prio_pick #(.UW(UDMA_N), .MW(MDMA_N), .SW(SDMA_N)) u_pick (
    .u_mask(u_mask), .m_mask(m_mask), .s_mask(s_mask),
    .req_mode(req_mode), .pick_mode(pick_mode));

  assign pkt_block = !is_disk && host_no_pkt_dma;
  assign next_mode = pkt_block ? 8'h00 : pick_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      mode <= 8'h00;
    end else begin
      done <= start;
      if (start) mode <= next_mode;
    end
  end
endmodule

// File: rtl/dma_mode_sel_chk.sv
module dma_mode_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic [7:0] mode,
  input logic [7:0] req_mode,
  input logic [2:0] id_ok,
  input logic       cable80,
  input logic       is_disk,
  input logic       host_no_pkt_dma
);
  // R2
  start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R2
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(mode));
  // R8
  ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mode <= $past(req_mode));
  // R9
  pkt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(!is_disk && host_no_pkt_dma)) |-> mode == 8'h00);
  // R5
  cable_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(cable80) && mode[7:6] == 2'b01) |-> mode <= 8'h42);
  // R4
  ultra_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode[7:6] == 2'b01) |-> $past(id_ok[2]));
  // R6
  mword_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode[7:4] == 4'h2) |-> $past(id_ok[1]));
endmodule

bind dma_mode_sel dma_mode_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .mode(mode),
  .req_mode(req_mode), .id_ok(id_ok), .cable80(cable80), .is_disk(is_disk),
  .host_no_pkt_dma(host_no_pkt_dma));

// File: tb/dma_mode_sel_test.sv
`timescale 1ns/1ps
module dma_mode_sel_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] id_ok = 3'b000;
  logic [6:0] drv_udma = '0, host_udma = '0;
  logic [2:0] drv_mwdma = '0, host_mwdma = '0, drv_swdma = '0, host_swdma = '0;
  logic [7:0] drv_sw_legacy = '0, req_mode = '0;
  logic cable80 = 1'b0, is_disk = 1'b1, host_no_pkt_dma = 1'b0;
  logic done;
  logic [7:0] mode;

  int checks = 0, failures = 0;
  string tag = "R1";
  logic exp_done = 1'b0;
  logic [7:0] exp_mode = 8'h00;

  always #2 clk = ~clk;

  dma_mode_sel uut (
    .clk(clk), .rst_n(rst_n), .start(start), .id_ok(id_ok),
    .drv_udma(drv_udma), .drv_mwdma(drv_mwdma), .drv_swdma(drv_swdma),
    .drv_sw_legacy(drv_sw_legacy), .host_udma(host_udma),
    .host_mwdma(host_mwdma), .host_swdma(host_swdma), .cable80(cable80),
    .is_disk(is_disk), .host_no_pkt_dma(host_no_pkt_dma),
    .req_mode(req_mode), .done(done), .mode(mode));

  // behavioural reference of the selection rules
  function automatic int model();
    int bases[3] = '{64, 32, 16};
    int req = int'(req_mode);
    int res = 0;
    if (!is_disk && host_no_pkt_dma) return 0;
    for (int f = 0; f < 3; f++) begin
      int m = 0;
      if (req < bases[f]) continue;
      if (f == 0) begin
        if (id_ok[2]) m = int'(drv_udma) & int'(host_udma);
        if (req > 66 && (m & 120) != 0 && !cable80) m = m & 7;
      end else if (f == 1) begin
        if (id_ok[1]) m = int'(drv_mwdma) & int'(host_mwdma);
      end else begin
        if (id_ok[1]) m = int'(drv_swdma) & int'(host_swdma);
        else if (drv_sw_legacy >= 1 && drv_sw_legacy <= 2)
          m = ((2 << drv_sw_legacy) - 1) & int'(host_swdma);
      end
      for (int b = 7; b >= 0; b--)
        if (m[b]) begin res = bases[f] + b; break; end
      if (res != 0) break;
    end
    if (res > req) res = req;
    return res;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_done <= 1'b0;
      exp_mode <= 8'h00;
    end else begin
      exp_done <= start;
      if (start) exp_mode <= 8'(model());
    end
  end

  task automatic check(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", t, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check({tag, " R2 done"}, {7'd0, done}, {7'd0, exp_done});
      check({tag, " mode"}, mode, exp_mode);
    end
  end

  task automatic run(string t, logic [7:0] exp);
    @(negedge clk);
    tag = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #0.5;
    check({t, " directed done"}, {7'd0, done}, 8'd1);
    check({t, " directed"}, mode, exp);
  endtask

  task automatic base_setup();
    id_ok = 3'b110; drv_udma = 7'h3F; host_udma = 7'h7F;
    drv_mwdma = 3'h7; host_mwdma = 3'h7; drv_swdma = 3'h7; host_swdma = 3'h7;
    drv_sw_legacy = 8'd0; cable80 = 1'b1; is_disk = 1'b1;
    host_no_pkt_dma = 1'b0; req_mode = 8'h46;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", {7'd0, done}, 8'd0);
    check("R1 reset mode", mode, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset mode", mode, 8'h00);

    base_setup();
    run("R3 ultra fastest", 8'h45);
    cable80 = 1'b0;
    run("R5 no cable cut", 8'h42);
    req_mode = 8'h42;
    run("R5 req at slow top", 8'h42);
    drv_udma = 7'h78; req_mode = 8'h43;
    run("R5 cut empties ultra", 8'h22);
    base_setup(); id_ok = 3'b010;
    run("R4 ultra word invalid", 8'h22);
    base_setup(); host_udma = 7'h0B; drv_udma = 7'h0E;
    run("R4 host and drive", 8'h43);
    base_setup(); host_mwdma = 3'h3; req_mode = 8'h3F;
    run("R6 mword host mask", 8'h21);
    base_setup(); req_mode = 8'h3F;
    run("R3 skip ultra", 8'h22);
    req_mode = 8'h21;
    run("R8 clamp to request", 8'h21);
    req_mode = 8'h1F;
    run("R3 single word", 8'h12);
    base_setup(); drv_mwdma = 3'h0; host_swdma = 3'h2; drv_udma = 7'h0;
    run("R6 sword host mask", 8'h11);
    base_setup(); id_ok = 3'b000; drv_sw_legacy = 8'd1;
    run("R7 legacy one", 8'h11);
    drv_sw_legacy = 8'd2; host_swdma = 3'h3;
    run("R7 legacy masked", 8'h11);
    drv_sw_legacy = 8'd3;
    run("R7 legacy out of range", 8'h00);
    drv_sw_legacy = 8'd0;
    run("R10 nothing usable", 8'h00);
    base_setup(); is_disk = 1'b0; host_no_pkt_dma = 1'b1;
    run("R9 packet blocked", 8'h00);
    host_no_pkt_dma = 1'b0;
    run("R9 packet allowed", 8'h45);
    req_mode = 8'h0F;
    run("R3 request below all", 8'h00);
    base_setup();
    run("R2 prime", 8'h45);
    tag = "R2 hold";
    req_mode = 8'h1F; id_ok = 3'b000;
    repeat (3) begin
      @(negedge clk);
      #0.5;
      check("R2 hold done", {7'd0, done}, 8'd0);
      check("R2 hold mode", mode, 8'h45);
    end
    for (int k = 0; k < 40; k++) begin
      id_ok = 3'(k * 5); drv_udma = 7'(k * 37 + 3); host_udma = 7'(k * 11 + 64);
      drv_mwdma = 3'(k); host_mwdma = 3'(k * 3 + 1);
      drv_swdma = 3'(k + 2); host_swdma = 3'(k * 7 + 5);
      drv_sw_legacy = 8'(k % 4); cable80 = k[1]; is_disk = ~k[3];
      host_no_pkt_dma = k[2]; req_mode = 8'(k * 13 % 80);
      run("R8 sweep", 8'(model()));
    end
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule